// File: doc/BRIEF.md
# Rolling-Readout Frame Timing Generator

This block sequences the readout of a rolling-shutter image sensor. It runs on the master clock, one pixel per clock, and turns five settings into the frame timing strobes: window width, horizontal blanking, window height, vertical blanking and an integration time counted in rows. The outputs are a frame-valid strobe, a line-valid strobe, a one-clock start-of-frame pulse, and column and row counters for the pixel currently read out.

A frame period has two parts. A vertical blanking interval comes first, and the active region follows it, with frame-valid held high. When the integration row count is larger than the readout can cover, the blanking interval grows by whole rows so that the exposure fits. The programmed blanking input keeps its value. Each blanking interval also carries a fixed four-clock overhead. The row length is enforced inside the block: horizontal blanking is raised as far as needed to reach the minimum row length and the minimum blanking. The settings are captured only at frame boundaries, so software may rewrite them at any time.

Top module: `sensor_frame_timer`

## Requirements
- R1: The row period in clocks equals width + H, where H is the largest of the programmed horizontal blanking, 43, and 660 − width. A row is never shorter than 660 clocks.
- R2: Within each active row, line_valid is high for exactly the first `width` clocks and low for the rest of the row.
- R3: frame_valid stays high without a break for height × row-period clocks, and the active region holds exactly `height` line_valid pulses.
- R4: When integ + 2 < height + vblank, the blanking interval lasts vblank × row-period + 4 clocks. This includes vblank = 0, which gives 4 clocks.
- R5: When integ + 2 ≥ height + vblank, the blanking interval lasts (integ + 2 − height) × row-period + 4 clocks. At the equality boundary this gives the same length as R4.
- R6: sof is high for one clock only, on the first clock of frame_valid. At that clock col_cnt and row_cnt are both 0.
- R7: During the active region, col_cnt counts 0 to row-period − 1 within each row and row_cnt counts 0 to height − 1. Outside the active region, both counters read 0.
- R8: The settings are captured while rst is high and on the last clock of each active region. A change made at any other time takes effect only in the next frame period.
- R9: A synchronous active-high rst forces frame_valid, line_valid and sof low and both counters to 0. Timing restarts at the beginning of a blanking interval, even when rst arrives in the middle of a frame.
- R10: With width 752, horizontal blanking 94, height 480, vblank 45 and integ 0, the row period is 846 clocks, line_valid lasts 752 clocks and the blanking interval lasts 38,074 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 11 | Window width in pixels (≥ 1) |
| cfg_hblank | input | 11 | Programmed horizontal blanking in clocks |
| cfg_height | input | 11 | Window height in rows (≥ 1) |
| cfg_vblank | input | 11 | Programmed vertical blanking in rows |
| cfg_integ | input | 12 | Integration time in rows |
| frame_valid | output | 1 | High across every active row |
| line_valid | output | 1 | High while active pixels are read out |
| sof | output | 1 | One-clock pulse on the first clock of frame_valid |
| col_cnt | output | 12 | Clock index within the active row |
| row_cnt | output | 11 | Row index within the active region |

## Verification
Several sets of settings are applied. Some have a programmed horizontal blanking long enough to be used as it is. Others have too small a width, so the 660-clock floor decides the row length. One has a blanking below 43, so the 43-clock floor decides it. These cases separate the three terms of the horizontal rule. On the vertical side, the integration row count is set below, equal to and above the stretch threshold, and one case has zero blanking rows. This shows whether the stretch condition and its formula are both right, including at the boundary. A run at the default settings confirms the absolute row and blanking lengths. Another run changes the settings once during blanking and once during the active region, which exposes any capture that happens at the wrong moment.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int COL_W = 11;
    localparam int ROW_W = 11;
    localparam int INT_W = 12;
    localparam int BRW_W = INT_W + 1;
    localparam int LEN_W = COL_W + 1;

    typedef enum logic [1:0] {
        PH_VTAIL  = 2'd0,
        PH_VROWS  = 2'd1,
        PH_ACTIVE = 2'd2
    } phase_t;

    typedef struct packed {
        logic [COL_W-1:0] width;
        logic [LEN_W-1:0] row_len;
        logic [ROW_W-1:0] height;
        logic [BRW_W-1:0] vrows;
    } geom_t;

    function automatic int eff_hblank(int w, int hb, int min_row, int min_hb);
        int r;
        r = hb;
        if (r < min_hb)      r = min_hb;
        if (r < min_row - w) r = min_row - w;
        return r;
    endfunction

    function automatic int blank_rows(int integ, int h, int vb);
        if (integ + 2 >= h + vb) return integ + 2 - h;
        return vb;
    endfunction

endpackage

// File: rtl/sft_geom.sv
module sft_geom
    import sft_pkg::*;
#(
    parameter int MIN_ROW_CLKS = 660,
    parameter int MIN_HBLANK   = 43
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] cfg_width,
    input  logic [COL_W-1:0] cfg_hblank,
    input  logic [ROW_W-1:0] cfg_height,
    input  logic [ROW_W-1:0] cfg_vblank,
    input  logic [INT_W-1:0] cfg_integ,
    output geom_t            geom
);

    geom_t nxt;

    always_comb begin
        int hb;
        hb = eff_hblank(int'(cfg_width), int'(cfg_hblank), MIN_ROW_CLKS, MIN_HBLANK);
        nxt.width   = cfg_width;
        nxt.row_len = LEN_W'(int'(cfg_width) + hb);
        nxt.height  = cfg_height;
        nxt.vrows   = BRW_W'(blank_rows(int'(cfg_integ), int'(cfg_height), int'(cfg_vblank)));
    end

    always_ff @(posedge clk) begin
        if (rst || load) geom <= nxt;
    end

    AST_ROW_FLOOR: assert property (@(posedge clk) disable iff (rst)
        geom.row_len >= LEN_W'(MIN_ROW_CLKS)); // R1

    AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(geom)); // R8

endmodule

// File: rtl/sft_seq.sv
module sft_seq
    import sft_pkg::*;
#(
    parameter int VBL_TAIL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  geom_t            geom,
    output logic             load,
    output logic             fv,
    output logic             lv,
    output logic             sof,
    output logic [LEN_W-1:0] col_cnt,
    output logic [ROW_W-1:0] row_cnt
);

    phase_t           ph;
    logic [LEN_W-1:0] col;
    logic [BRW_W-1:0] row;
    logic             last_col, last_tail, last_vrow, last_arow;

    assign last_col  = (col == geom.row_len - LEN_W'(1));
    assign last_tail = (col == LEN_W'(VBL_TAIL - 1));
    assign last_vrow = (row == geom.vrows - BRW_W'(1));
    assign last_arow = (row == BRW_W'(geom.height) - BRW_W'(1));
    assign load      = (ph == PH_ACTIVE) && last_col && last_arow;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_VTAIL;
            col <= '0;
            row <= '0;
        end else begin
            case (ph)
                PH_VTAIL: begin
                    if (last_tail) begin
                        col <= '0;
                        row <= '0;
                        ph  <= (geom.vrows == '0) ? PH_ACTIVE : PH_VROWS;
                    end else begin
                        col <= col + LEN_W'(1);
                    end
                end
                PH_VROWS: begin
                    if (last_col) begin
                        col <= '0;
                        if (last_vrow) begin
                            row <= '0;
                            ph  <= PH_ACTIVE;
                        end else begin
                            row <= row + BRW_W'(1);
                        end
                    end else begin
                        col <= col + LEN_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (last_col) begin
                        col <= '0;
                        if (last_arow) begin
                            row <= '0;
                            ph  <= PH_VTAIL;
                        end else begin
                            row <= row + BRW_W'(1);
                        end
                    end else begin
                        col <= col + LEN_W'(1);
                    end
                end
                default: begin
                    ph  <= PH_VTAIL;
                    col <= '0;
                    row <= '0;
                end
            endcase
        end
    end

    always_comb begin
        fv      = (ph == PH_ACTIVE);
        lv      = fv && (col < LEN_W'(geom.width));
        sof     = fv && (col == '0) && (row == '0);
        col_cnt = fv ? col : '0;
        row_cnt = fv ? row[ROW_W-1:0] : '0;
    end

    AST_SOF_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(fv) |-> sof); // R6

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof); // R6

    AST_LV_IN_FV: assert property (@(posedge clk) disable iff (rst)
        lv |-> fv); // R2

    AST_LV_FALL_COL: assert property (@(posedge clk) disable iff (rst)
        $fell(lv) |-> (fv && col_cnt == LEN_W'(geom.width))); // R2

    AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fv |-> (row_cnt < geom.height)); // R3

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fv |-> (!lv && !sof && col_cnt == '0 && row_cnt == '0)); // R7

endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
    import sft_pkg::*;
#(
    parameter int MIN_ROW_CLKS = 660,
    parameter int MIN_HBLANK   = 43,
    parameter int VBL_TAIL     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COL_W-1:0] cfg_width,
    input  logic [COL_W-1:0] cfg_hblank,
    input  logic [ROW_W-1:0] cfg_height,
    input  logic [ROW_W-1:0] cfg_vblank,
    input  logic [INT_W-1:0] cfg_integ,
    output logic             frame_valid,
    output logic             line_valid,
    output logic             sof,
    output logic [LEN_W-1:0] col_cnt,
    output logic [ROW_W-1:0] row_cnt
);

    geom_t geom;
    logic  load;

    sft_geom #(
        .MIN_ROW_CLKS(MIN_ROW_CLKS),
        .MIN_HBLANK  (MIN_HBLANK)
    ) u_geom (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .cfg_width (cfg_width),
        .cfg_hblank(cfg_hblank),
        .cfg_height(cfg_height),
        .cfg_vblank(cfg_vblank),
        .cfg_integ (cfg_integ),
        .geom      (geom)
    );

    sft_seq #(
        .VBL_TAIL(VBL_TAIL)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .geom   (geom),
        .load   (load),
        .fv     (frame_valid),
        .lv     (line_valid),
        .sof    (sof),
        .col_cnt(col_cnt),
        .row_cnt(row_cnt)
    );

    AST_LOAD_AT_FV_END: assert property (@(posedge clk) disable iff (rst)
        load |=> !frame_valid); // R8

endmodule

// File: tb/sensor_frame_timer_test.sv
`timescale 1ns/1ps
module sensor_frame_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] cfg_width, cfg_hblank, cfg_height, cfg_vblank;
    logic [11:0] cfg_integ;
    logic        frame_valid, line_valid, sof;
    logic [11:0] col_cnt;
    logic [10:0] row_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sensor_frame_timer uut (
        .clk(clk), .rst(rst),
        .cfg_width(cfg_width), .cfg_hblank(cfg_hblank), .cfg_height(cfg_height),
        .cfg_vblank(cfg_vblank), .cfg_integ(cfg_integ),
        .frame_valid(frame_valid), .line_valid(line_valid), .sof(sof),
        .col_cnt(col_cnt), .row_cnt(row_cnt)
    );

    // width, hblank, height, vblank, integ, row period, blank clocks, stretch-case flag
    localparam int NV = 8;
    localparam int VEC [NV][8] = '{
        '{700, 50, 3, 2, 0, 750, 1504, 0},
        '{100, 43, 2, 1, 0, 660,  664, 0},
        '{640, 10, 2, 3, 0, 683, 2053, 0},
        '{700, 60, 2, 1, 5, 760, 3804, 1},
        '{700, 60, 3, 4, 5, 760, 3044, 1},
        '{700, 60, 3, 2, 4, 760, 2284, 1},
        '{700, 60, 3, 2, 2, 760, 1524, 0},
        '{617,  0, 2, 0, 0, 660,    4, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int w, input int hb, input int h, input int vb, input int it);
        cfg_width  = 11'(w);
        cfg_hblank = 11'(hb);
        cfg_height = 11'(h);
        cfg_vblank = 11'(vb);
        cfg_integ  = 12'(it);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 fv in reset", int'(frame_valid), 0);
        check("R9 lv/sof in reset", int'(line_valid) + int'(sof), 0);
        check("R9 counters in reset", int'(col_cnt) + int'(row_cnt), 0);
        rst = 1'b0;
    endtask

    task automatic meas_blank(output int n);
        n = 0;
        while (!frame_valid) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic meas_active(output int fvn, output int lvw, output int rowp,
                               output int nl, output int sofn, output int lastrow,
                               output int lastcol, output int firstok);
        logic prev_lv;
        prev_lv = 1'b0;
        fvn = 0; lvw = 0; rowp = 0; nl = 0; sofn = 0; lastrow = 0; lastcol = 0; firstok = 0;
        while (frame_valid) begin
            if (sof) sofn++;
            if (fvn == 0) firstok = int'(sof && col_cnt == 0 && row_cnt == 0);
            if (line_valid && !prev_lv) begin
                nl++;
                if (nl == 2) rowp = fvn;
            end
            if (line_valid && nl == 1) lvw++;
            lastrow = int'(row_cnt);
            lastcol = int'(col_cnt);
            prev_lv = line_valid;
            fvn++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 180000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bl, fvn, lvw, rowp, nl, sofn, lr, lc, fok;
        set_cfg(752, 94, 480, 45, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
            do_reset();
            meas_blank(bl);
            check(VEC[i][7] != 0 ? "R5 stretched blanking" : "R4 normal blanking", bl, VEC[i][6]);
            meas_active(fvn, lvw, rowp, nl, sofn, lr, lc, fok);
            check("R1 row period", rowp, VEC[i][5]);
            check("R2 line_valid width", lvw, VEC[i][0]);
            check("R3 frame_valid length", fvn, VEC[i][2] * VEC[i][5]);
            check("R3 line count", nl, VEC[i][2]);
            check("R6 sof count", sofn, 1);
            check("R6 sof on first fv clock", fok, 1);
            check("R7 last row_cnt", lr, VEC[i][2] - 1);
            check("R7 last col_cnt", lc, VEC[i][5] - 1);
            check("R7 counters idle after fv", int'(col_cnt) + int'(row_cnt), 0);
        end

        // R8: changes during blanking and mid-frame apply only to the next frame
        set_cfg(100, 43, 2, 1, 0);
        do_reset();
        set_cfg(700, 50, 3, 2, 0);
        meas_blank(bl);
        check("R8 blank uses captured cfg", bl, 664);
        meas_active(fvn, lvw, rowp, nl, sofn, lr, lc, fok);
        check("R8 active uses captured cfg", fvn, 1320);
        meas_blank(bl);
        check("R8 new cfg next blanking", bl, 1504);
        set_cfg(100, 43, 2, 1, 0);
        meas_active(fvn, lvw, rowp, nl, sofn, lr, lc, fok);
        check("R8 mid-frame change ignored", fvn, 2250);
        check("R8 mid-frame width ignored", lvw, 700);
        meas_blank(bl);
        check("R8 change applies next frame", bl, 664);

        // R10: default settings
        set_cfg(752, 94, 480, 45, 0);
        do_reset();
        meas_blank(bl);
        check("R10 default blanking", bl, 38074);
        lvw = 0;
        while (line_valid) begin lvw++; @(negedge clk); end
        check("R10 default line_valid", lvw, 752);
        rowp = lvw;
        while (!line_valid) begin rowp++; @(negedge clk); end
        check("R10 default row period", rowp, 846);

        // R9: reset in the middle of the active region
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid-frame reset fv", int'(frame_valid) + int'(line_valid), 0);
        check("R9 mid-frame reset counters", int'(col_cnt) + int'(row_cnt), 0);
        set_cfg(100, 43, 2, 1, 0);
        @(negedge clk);
        rst = 1'b0;
        meas_blank(bl);
        check("R9 restart at blanking start", bl, 664);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule